// File: doc/BRIEF.md
# PDM Microphone Clock and Capture Front End

This block produces the bit clock driven out to pulse-density-modulated microphones and samples their one-bit data streams. The bit clock is derived from a fast source clock. It can be divided by an even ratio, it can bypass the divider and pass the source clock straight through, or it can be held low by an output enable. Clock generation runs only while a run control is high. A soft reset pulse returns every counter and every captured bit to the idle state.

Each of the ten data inputs goes through a two-flop synchronizer. Sampling then takes place a programmable number of source cycles into the bit-clock phase that the channel's polarity bit selects. Channels 0 to 7 carry microphone data and channels 8 and 9 carry reference streams. All channels are sampled in the same way. Each enabled channel delivers its captured bit together with a one-cycle valid strobe, once per bit-clock period. Changes to the divider code or to the bypass control are held until the end of the current period, so a reconfiguration never shortens a phase.

Top module: `pdm_frontend`

## Requirements
- R1: In divided mode, each high phase and each low phase of `pdm_clk_out` lasts `max(div_code,1)+1` source cycles. The period is therefore `2*(div_code+1)`, and code 0 behaves like code 1 (divide by 4).
- R2: While pass-through is active, `pdm_clk_out` is high when `clk_src` is high and low when `clk_src` is low.
- R3: With `clk_oe` low, `pdm_clk_out` stays low in every mode, and capture continues.
- R4: A new `div_code` or `div_bypass` value takes effect only at the end of a low phase (the period boundary). The current high phase and the current low phase keep their old lengths.
- R5: In divided mode, a channel samples in the cycle where the bit clock is at the level given by its `ch_pol` bit (1 means high, 0 means low) and the phase position, counted from 0, equals `min(capt_dly, phase_length-1)`. `cap_valid` is high in the following cycle. `cap_bit` changes only in cycles where its strobe is high.
- R6: The captured bit equals the value of `pdm_din` at the source edge two cycles before the sampling edge. This delay comes from the two-flop synchronizer.
- R7: Each enabled channel raises exactly one strobe per bit-clock period. A channel whose `ch_en` bit was low at the sampling edge never raises its strobe.
- R8: In pass-through mode, every enabled channel samples on every source cycle, and polarity and delay are ignored.
- R9: With `run_en` low, `pdm_clk_out` is low, the divider is idle, and no strobe is raised.
- R10: After a `soft_rst` pulse, all strobes and captured bits are 0 and the bit clock restarts from the beginning of a low phase.
- R11: During reset, `pdm_clk_out`, `cap_bit` and `cap_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous clear pulse |
| run_en | input | 1 | Starts bit-clock generation and capture |
| div_code | input | 4 | Divider code n, ratio 2*(n+1), minimum 4 |
| div_bypass | input | 1 | Selects pass-through of the source clock |
| clk_oe | input | 1 | Enables the bit-clock pin |
| capt_dly | input | 4 | Sampling position within the selected phase |
| ch_en | input | 10 | Per-channel enable |
| ch_pol | input | 10 | Per-channel phase select, 1 = high phase |
| pdm_din | input | 10 | Asynchronous one-bit data streams |
| pdm_clk_out | output | 1 | Bit clock to the microphones |
| cap_bit | output | 10 | Last captured bit per channel |
| cap_valid | output | 10 | One-cycle strobe per capture |

## Verification
A wrong phase counter or a wrong latched divider shows up at the pin within one phase, as a high or low run of the wrong length. A wrong polarity or delay decode moves the strobe to a different source cycle relative to the last pin edge. This is visible on the first capture after the fault. An error in the synchronizer depth is caught by comparing `cap_bit` with the stimulus history, because the inputs change every cycle. A mis-timed configuration latch breaks the phase length of the period right after the change.

// File: rtl/pdmfe_pkg.sv
package pdmfe_pkg;

  localparam int unsigned CH_NUM = 10;
  localparam int unsigned DIV_W  = 4;
  localparam int unsigned DLY_W  = 4;

  // Source of the bit clock chosen at a period boundary
  typedef enum logic {
    SRC_DIV  = 1'b0,
    SRC_PASS = 1'b1
  } clk_src_e;

endpackage

// File: rtl/pdmfe_rst_sync.sv
module pdmfe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_out
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_out = stage_q[1];

endmodule

// File: rtl/pdmfe_clkgen.sv
module pdmfe_clkgen
  import pdmfe_pkg::*;
#(
  parameter int unsigned DIV_W = pdmfe_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic             run,
  input  logic             byp_req,
  input  logic [DIV_W-1:0] div_code,
  output logic             lvl,
  output logic [DIV_W-1:0] phase_cnt,
  output logic [DIV_W-1:0] half_m1,
  output clk_src_e         src_sel
);

  logic             lvl_n;
  logic [DIV_W-1:0] cnt_n;
  logic [DIV_W-1:0] hm1_n;
  clk_src_e         sel_n;
  logic [DIV_W-1:0] req_hm1;
  clk_src_e         req_sel;
  logic             phase_end;

  // Requested settings; the ratio never drops below 4
  always_comb begin
    req_hm1   = (div_code == '0) ? DIV_W'(1) : div_code;
    req_sel   = byp_req ? SRC_PASS : SRC_DIV;
    phase_end = (phase_cnt == half_m1);
  end

  always_comb begin
    lvl_n = lvl;
    cnt_n = phase_cnt;
    hm1_n = half_m1;
    sel_n = src_sel;
    if (soft_clr || !run) begin
      lvl_n = 1'b0;
      cnt_n = '0;
      hm1_n = req_hm1;
      sel_n = req_sel;
    end else if (src_sel == SRC_PASS) begin
      // every source cycle is a boundary in pass-through
      lvl_n = 1'b0;
      cnt_n = '0;
      hm1_n = req_hm1;
      sel_n = req_sel;
    end else if (phase_end) begin
      cnt_n = '0;
      if (lvl) begin
        lvl_n = 1'b0;
      end else begin
        // end of low phase: period boundary, settings may change here
        hm1_n = req_hm1;
        sel_n = req_sel;
        lvl_n = (req_sel == SRC_DIV);
      end
    end else begin
      cnt_n = phase_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl       <= 1'b0;
      phase_cnt <= '0;
      half_m1   <= DIV_W'(1);
      src_sel   <= SRC_DIV;
    end else begin
      lvl       <= lvl_n;
      phase_cnt <= cnt_n;
      half_m1   <= hm1_n;
      src_sel   <= sel_n;
    end
  end

endmodule

// File: rtl/pdmfe_chan.sv
module pdmfe_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_clr,
  input  logic din,
  input  logic take,
  output logic bit_q,
  output logic valid_q
);

  logic [1:0] sync_q;
  logic [1:0] sync_n;
  logic       bit_n;
  logic       valid_n;

  always_comb begin
    sync_n  = {sync_q[0], din};
    bit_n   = bit_q;
    valid_n = take;
    if (take) begin
      bit_n = sync_q[1];
    end
    if (soft_clr) begin
      sync_n  = 2'b00;
      bit_n   = 1'b0;
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b00;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sync_q  <= sync_n;
      bit_q   <= bit_n;
      valid_q <= valid_n;
    end
  end

endmodule

// File: rtl/pdm_frontend.sv
module pdm_frontend
  import pdmfe_pkg::*;
#(
  parameter int unsigned NUM_CH = pdmfe_pkg::CH_NUM,
  parameter int unsigned DIV_W  = pdmfe_pkg::DIV_W,
  parameter int unsigned DLY_W  = pdmfe_pkg::DLY_W
) (
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              run_en,
  input  logic [DIV_W-1:0]  div_code,
  input  logic              div_bypass,
  input  logic              clk_oe,
  input  logic [DLY_W-1:0]  capt_dly,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_pol,
  input  logic [NUM_CH-1:0] pdm_din,
  output logic              pdm_clk_out,
  output logic [NUM_CH-1:0] cap_bit,
  output logic [NUM_CH-1:0] cap_valid
);

  localparam int unsigned CMP_W = (DIV_W > DLY_W) ? DIV_W : DLY_W;

  logic             rst_int_n;
  logic             clk_lvl;
  logic [DIV_W-1:0] phase_cnt;
  logic [DIV_W-1:0] half_m1;
  clk_src_e         src_sel;
  logic             pass_mode;
  logic [CMP_W-1:0] dly_x;
  logic [CMP_W-1:0] hm1_x;
  logic [CMP_W-1:0] dly_eff;
  logic             phase_hit;
  logic [NUM_CH-1:0] take;

  pdmfe_rst_sync u_rst (
    .clk       (clk_src),
    .arst_n    (rst_n),
    .rst_n_out (rst_int_n)
  );

  pdmfe_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk_src),
    .rst_n     (rst_int_n),
    .soft_clr  (soft_rst),
    .run       (run_en),
    .byp_req   (div_bypass),
    .div_code  (div_code),
    .lvl       (clk_lvl),
    .phase_cnt (phase_cnt),
    .half_m1   (half_m1),
    .src_sel   (src_sel)
  );

  // Sampling position, clamped to the last cycle of a phase
  always_comb begin
    pass_mode = (src_sel == SRC_PASS);
    dly_x     = CMP_W'(capt_dly);
    hm1_x     = CMP_W'(half_m1);
    dly_eff   = (dly_x > hm1_x) ? hm1_x : dly_x;
    phase_hit = (CMP_W'(phase_cnt) == dly_eff);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign take[g] = run_en & ch_en[g] &
                     (pass_mode | (phase_hit & (clk_lvl == ch_pol[g])));

    pdmfe_chan u_chan (
      .clk      (clk_src),
      .rst_n    (rst_int_n),
      .soft_clr (soft_rst),
      .din      (pdm_din[g]),
      .take     (take[g]),
      .bit_q    (cap_bit[g]),
      .valid_q  (cap_valid[g])
    );
  end

  assign pdm_clk_out = clk_oe & run_en & (pass_mode ? clk_src : clk_lvl);

endmodule

// File: rtl/pdm_frontend_chk.sv
module pdm_frontend_chk #(
  parameter int unsigned NUM_CH = 10
) (
  input logic              clk_src,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              run_en,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] cap_valid,
  input logic [NUM_CH-1:0] cap_bit,
  input logic              clk_lvl
);

  // R1: a divided high phase is never shorter than two source cycles
  assert_high_min_R1: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($rose(clk_lvl) && run_en && !soft_rst) |=> clk_lvl);

  // R9: no strobe after a cycle with run low
  assert_idle_quiet_R9: assert property (@(posedge clk_src) disable iff (!rst_n)
    !run_en |=> (cap_valid == '0));

  // R10: soft reset clears strobes and captured bits
  assert_soft_clear_R10: assert property (@(posedge clk_src) disable iff (!rst_n)
    soft_rst |=> ((cap_valid == '0) && (cap_bit == '0)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    // R7: a disabled channel stays silent
    assert_off_silent_R7: assert property (@(posedge clk_src) disable iff (!rst_n)
      !ch_en[g] |=> !cap_valid[g]);

    // R5: the captured bit moves only together with its strobe
    assert_bit_hold_R5: assert property (@(posedge clk_src) disable iff (!rst_n)
      (!cap_valid[g] && !$past(soft_rst)) |-> $stable(cap_bit[g]));
  end

endmodule

bind pdm_frontend pdm_frontend_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_src   (clk_src),
  .rst_n     (rst_n),
  .soft_rst  (soft_rst),
  .run_en    (run_en),
  .ch_en     (ch_en),
  .cap_valid (cap_valid),
  .cap_bit   (cap_bit),
  .clk_lvl   (clk_lvl)
);

// File: tb/pdm_frontend_bench.sv
module pdm_frontend_bench;

  localparam int NCH = 10;
  localparam int CLK_PERIOD = 10;

  logic           clk_src = 1'b0;
  logic           rst_n = 1'b0;
  logic           soft_rst = 1'b0;
  logic           run_en = 1'b0;
  logic [3:0]     div_code = 4'd0;
  logic           div_bypass = 1'b0;
  logic           clk_oe = 1'b1;
  logic [3:0]     capt_dly = 4'd0;
  logic [NCH-1:0] ch_en = '0;
  logic [NCH-1:0] ch_pol = '0;
  logic [NCH-1:0] pdm_din = '0;
  wire            pdm_clk_out;
  wire [NCH-1:0]  cap_bit;
  wire [NCH-1:0]  cap_valid;

  pdm_frontend u_pdm_frontend (
    .clk_src     (clk_src),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .run_en      (run_en),
    .div_code    (div_code),
    .div_bypass  (div_bypass),
    .clk_oe      (clk_oe),
    .capt_dly    (capt_dly),
    .ch_en       (ch_en),
    .ch_pol      (ch_pol),
    .pdm_din     (pdm_din),
    .pdm_clk_out (pdm_clk_out),
    .cap_bit     (cap_bit),
    .cap_valid   (cap_valid)
  );

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hm1_of(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int deff(input int d, input int h);
    return (d > h) ? h : d;
  endfunction

  // inputs as seen by the design at the last rising edge
  logic [NCH-1:0] s_en = '0, s_pol = '0;
  logic [3:0]     s_dly = '0, s_div = '0;
  logic           s_run = 1'b0;
  always @(posedge clk_src) begin
    s_en  <= ch_en;
    s_pol <= ch_pol;
    s_dly <= capt_dly;
    s_div <= div_code;
    s_run <= run_en;
  end

  // monitor state
  logic           mon_on = 1'b0;
  logic           mode_byp = 1'b0;
  int             k = 0, prev_k = 0, exp_hm1 = 1, prev_hm1 = 1;
  logic           last_pin = 1'b0, prev_pin = 1'b0, armed = 1'b0;
  int             vcnt [NCH];
  logic [NCH-1:0] hist0 = '0, hist1 = '0, hist2 = '0, nd = '0;

  initial for (int i = 0; i < NCH; i++) vcnt[i] = 0;

  always @(negedge clk_src) begin
    if (mon_on) begin
      if (mode_byp) begin
        chk(cap_valid == (s_run ? s_en : '0), "R8 strobe every cycle",
            int'(cap_valid), int'(s_run ? s_en : '0));
      end else begin
        chk((cap_valid & ~s_en) == '0, "R7 disabled channel silent",
            int'(cap_valid & ~s_en), 0);
        for (int i = 0; i < NCH; i++) begin
          if (cap_valid[i]) begin
            chk((prev_pin == s_pol[i]) && (prev_k == deff(int'(s_dly), prev_hm1)),
                "R5 sample phase/position", prev_k, deff(int'(s_dly), prev_hm1));
            vcnt[i]++;
          end
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (cap_valid[i]) begin
          chk(cap_bit[i] == hist2[i], "R6 captured data", int'(cap_bit[i]), int'(hist2[i]));
        end
      end
    end
    // bit-clock tracking
    if (!s_run) begin
      k = 0;
      last_pin = 1'b0;
      armed = 1'b0;
      exp_hm1 = hm1_of(int'(s_div));
      for (int i = 0; i < NCH; i++) vcnt[i] = 0;
    end else if (pdm_clk_out != last_pin) begin
      if (mon_on && !mode_byp && armed) begin
        chk(k == exp_hm1, "R1/R4 phase length", k + 1, exp_hm1 + 1);
      end
      if (pdm_clk_out) begin
        if (mon_on && !mode_byp && armed) begin
          for (int i = 0; i < NCH; i++) begin
            chk(vcnt[i] == (ch_en[i] ? 1 : 0), "R7 strobes per period",
                vcnt[i], ch_en[i] ? 1 : 0);
          end
        end
        for (int i = 0; i < NCH; i++) vcnt[i] = 0;
        armed = 1'b1;
        exp_hm1 = hm1_of(int'(s_div));
      end
      k = 0;
      last_pin = pdm_clk_out;
    end else begin
      k++;
    end
    prev_k = k;
    prev_pin = pdm_clk_out;
    prev_hm1 = exp_hm1;
    // fresh stimulus every cycle
    hist2 = hist1;
    hist1 = hist0;
    nd = NCH'($urandom);
    hist0 = nd;
    pdm_din = nd;
  end

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_src);
    #1;
  endtask

  task automatic run_seg(input int dv, input int dl, input logic [NCH-1:0] pl,
                         input logic [NCH-1:0] en, input int periods);
    run_en = 1'b0;
    cyc(2);
    div_code = 4'(dv);
    capt_dly = 4'(dl);
    ch_pol = pl;
    ch_en = en;
    cyc(2);
    run_en = 1'b1;
    cyc(periods * 2 * (hm1_of(dv) + 1));
    run_en = 1'b0;
    cyc(1);
  endtask

  initial begin
    int vseen;
    // R11: reset state, even with run and channels requested
    run_en = 1'b1;
    ch_en = '1;
    cyc(3);
    chk(pdm_clk_out == 1'b0, "R11 pin in reset", int'(pdm_clk_out), 0);
    chk(cap_valid == '0, "R11 strobes in reset", int'(cap_valid), 0);
    chk(cap_bit == '0, "R11 bits in reset", int'(cap_bit), 0);
    run_en = 1'b0;
    cyc(1);
    rst_n = 1'b1;
    cyc(4);
    mon_on = 1'b1;

    // R1 R5 R6 R7: sweep of divider codes and delays (incl. clamp)
    for (int dv = 0; dv <= 4; dv++) begin
      for (int dl = 0; dl <= 6; dl++) begin
        run_seg(dv, dl, NCH'(10'h2B5 ^ (dv * 37 + dl * 91)),
                ((dv + dl) % 2 == 0) ? 10'h3FF : 10'h2DB, 6);
      end
    end

    // R4: divider change during a high phase, then during a low phase
    run_en = 1'b0;
    div_code = 4'd2;
    capt_dly = 4'd1;
    ch_en = 10'h3FF;
    ch_pol = 10'h155;
    cyc(2);
    run_en = 1'b1;
    cyc(20);
    while (pdm_clk_out !== 1'b1) @(negedge clk_src);
    #1 div_code = 4'd4;
    cyc(60);
    while (pdm_clk_out !== 1'b0) @(negedge clk_src);
    #1 div_code = 4'd0;
    cyc(40);
    run_en = 1'b0;
    cyc(2);

    // R8 R2: pass-through
    mode_byp = 1'b1;
    div_bypass = 1'b1;
    ch_en = 10'h1E7;
    cyc(2);
    run_en = 1'b1;
    cyc(20);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_src); #1;
      chk(pdm_clk_out == 1'b1, "R2 pass-through high", int'(pdm_clk_out), 1);
      @(negedge clk_src); #1;
      chk(pdm_clk_out == 1'b0, "R2 pass-through low", int'(pdm_clk_out), 0);
    end
    // R3 in pass-through
    clk_oe = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_src); #1;
      chk(pdm_clk_out == 1'b0, "R3 gated pass-through", int'(pdm_clk_out), 0);
    end
    cyc(1);
    clk_oe = 1'b1;
    run_en = 1'b0;
    cyc(2);
    mode_byp = 1'b0;
    div_bypass = 1'b0;
    cyc(2);

    // R3: divided mode with the pin disabled
    mon_on = 1'b0;
    div_code = 4'd1;
    capt_dly = 4'd0;
    ch_en = 10'h3FF;
    clk_oe = 1'b0;
    cyc(2);
    run_en = 1'b1;
    vseen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_src); #1;
      chk(pdm_clk_out == 1'b0, "R3 pin held low", int'(pdm_clk_out), 0);
      if (cap_valid != '0) vseen++;
    end
    chk(vseen > 0, "R3 capture continues", vseen, 1);

    // R10: soft reset mid-run
    clk_oe = 1'b1;
    cyc(7);
    soft_rst = 1'b1;
    cyc(1);
    chk(cap_valid == '0, "R10 strobes cleared", int'(cap_valid), 0);
    chk(cap_bit == '0, "R10 bits cleared", int'(cap_bit), 0);
    chk(pdm_clk_out == 1'b0, "R10 clock restarts low", int'(pdm_clk_out), 0);
    soft_rst = 1'b0;
    cyc(1);
    chk(pdm_clk_out == 1'b0, "R10 first phase low", int'(pdm_clk_out), 0);

    // R9: idle
    run_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_src); #1;
      chk(pdm_clk_out == 1'b0, "R9 pin idle", int'(pdm_clk_out), 0);
      chk(cap_valid == '0, "R9 no strobe idle", int'(cap_valid), 0);
    end
    mon_on = 1'b1;
    run_seg(3, 2, 10'h0F0, 10'h3FF, 4);

    finish_up();
  end

endmodule